// File: doc/BRIEF.md
# Board Reset Issuer with Cause Capture

This block sits in board management logic. It issues a timed board reset and keeps a record of what caused the most recent one. Several sources can ask for a reset:

- a rear-module button and a front-panel button, both asynchronous, so each passes through a synchronizer;
- debug-header hard and soft requests;
- a payload reset from the management controller;
- a board reset issued by management software;
- a CPU hard-reset request;
- software, writing a command register.

The block answers the first request that arrives while it is idle. It drives `boardRst` for a fixed number of cycles. On the cycle the pulse begins, it stores a one-hot cause code in a read-only status register.

After a true power-on, the block runs a full reset pulse of its own. That power-on pulse is not recorded as a front-panel event, so the status register reads zero. A power-up flag reads one until the first later reset begins. Software can request a hard or a soft reset by writing one bit of the write-only command register. The command bit stays set for the length of the pulse and then clears itself.

Top module: `rstCauseCtl`

## Requirements
- R1: While `porN` is low, `boardRst` is 1, the status register is 0 and `pwrUpFlag` is 1. After `porN` rises, `boardRst` stays 1 for `RST_CYCLES` more rising edges, then falls. The power-on pulse leaves the status register at 0.
- R2: A reset started by any request holds `boardRst` high for exactly `RST_CYCLES` clock cycles (16 by default). The cause is stored on the same edge that raises `boardRst`.
- R3: The status register (address 0) holds at most one set bit. Its encoding is: bit 7 rear button, bit 6 software hard command, bit 5 CPU hard request, bit 4 debug or software soft reset, bit 3 debug hard reset, bit 2 payload reset, bit 1 software board reset, bit 0 front-panel button. Each new reset replaces the old code.
- R4: A front-panel button press after power-up is stored as 0x01. The power-on reset itself is never stored.
- R5: `pwrUpFlag` (also readable as bit 0 of address 2) is 1 after power-on. It clears on the edge that starts the first later reset, and only `porN` sets it again.
- R6: Writing 0x01 to the command register (address 1) starts a hard reset with cause 0x40. Writing 0x02 starts a soft reset with cause 0x10. The pulse begins on the same edge that accepts the write. The command bit stays set while `boardRst` is high and clears when the pulse ends.
- R7: A command write is ignored, and no reset starts, if its data has no bit set, has both bits 1:0 set, or has any bit in 7:2 set.
- R8: A read of the command address returns 0 at all times.
- R9: Button inputs pass through a two-flop synchronizer and a rising-edge detector. A button that rises before edge k starts a reset on edge k+2. A button held high triggers only one reset.
- R10: If several requests arrive on the same cycle, the highest-numbered cause bit is stored.
- R11: The level request inputs are edge-detected. A request edge that arrives while `boardRst` is high is dropped: it neither changes the status nor starts a later reset.
- R12: Read data is registered. The value of a read accepted on edge k appears on `busRdData` after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rearBtn | input | 1 | Rear-module push button, asynchronous |
| frontBtn | input | 1 | Front-panel push button, asynchronous |
| cpuHardReq | input | 1 | CPU hard-reset request, synchronous level |
| dbgSoftReq | input | 1 | Debug-header soft reset, synchronous level |
| dbgHardReq | input | 1 | Debug-header hard reset, synchronous level |
| payloadReq | input | 1 | Payload reset from the management controller |
| mgrBoardReq | input | 1 | Board reset issued by management software |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Register address |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Registered read data |
| boardRst | output | 1 | Board reset output, active high |
| pwrUpFlag | output | 1 | First-power-up flag |

## Verification
These are the expected latencies:

- A pulse on a level request, or a command write held between two falling edges, raises `boardRst` at the next rising edge. It is therefore visible at the falling edge where the stimulus ends.
- A button change is visible only at the third falling edge after it is applied.
- Read data is due one falling edge after the read strobe is sampled.

The bench samples exactly at these falling edges. It then counts the falling edges at which `boardRst` is still high, which gives the pulse width. A queue of expected read values is popped by a monitor one cycle after each sampled read strobe, so every comparison lines up with the registered read path.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int CAUSE_W   = 8;
  localparam int CMD_BITS  = 2;
  // cause bit positions (bit order sets priority)
  localparam int C_FRONT   = 0;
  localparam int C_SWBOARD = 1;
  localparam int C_PAYLOAD = 2;
  localparam int C_DBGHARD = 3;
  localparam int C_SOFT    = 4;
  localparam int C_CPUHARD = 5;
  localparam int C_SWHARD  = 6;
  localparam int C_REAR    = 7;
  // register addresses
  localparam int A_STATUS  = 0;
  localparam int A_CMD     = 1;
  localparam int A_FLAG    = 2;

  typedef struct packed {
    logic               start;
    logic               finish;
    logic [CAUSE_W-1:0] cause;
  } rccStb_t;

  // keep only the highest set bit
  function automatic logic [CAUSE_W-1:0] pickTop(input logic [CAUSE_W-1:0] v);
    logic [CAUSE_W-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = CAUSE_W - 1; i >= 0; i--) begin
      if (v[i] && !found) begin
        r[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rccDatapath.sv
module rccDatapath
  import rcc_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               rearBtn,
  input  logic               frontBtn,
  input  logic               cpuHardReq,
  input  logic               dbgSoftReq,
  input  logic               dbgHardReq,
  input  logic               payloadReq,
  input  logic               mgrBoardReq,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  rccStb_t            stb,
  output logic [CAUSE_W-1:0] reqVec,
  output logic [CAUSE_W-1:0] statusQ,
  output logic [CMD_BITS-1:0] cmdQ,
  output logic               pwrUpFlag
);
  localparam int NBTN = 2;
  localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(A_STATUS);
  localparam logic [ADDR_W-1:0] ADR_CMD    = ADDR_W'(A_CMD);
  localparam logic [ADDR_W-1:0] ADR_FLAG   = ADDR_W'(A_FLAG);

  // button synchronizers
  logic [NBTN-1:0] btnRaw;
  logic [NBTN-1:0] btnSync;
  assign btnRaw = {rearBtn, frontBtn};

  for (genvar b = 0; b < NBTN; b++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) sh <= '0;
      else       sh <= {sh[SYNC_STAGES-2:0], btnRaw[b]};
    end
    assign btnSync[b] = sh[SYNC_STAGES-1];
  end

  // level vector in cause-bit positions
  logic [CAUSE_W-1:0] lvlNow;
  logic [CAUSE_W-1:0] lvlPrev;
  logic [CAUSE_W-1:0] edges;

  always_comb begin
    lvlNow            = '0;
    lvlNow[C_FRONT]   = btnSync[0];
    lvlNow[C_SWBOARD] = mgrBoardReq;
    lvlNow[C_PAYLOAD] = payloadReq;
    lvlNow[C_DBGHARD] = dbgHardReq;
    lvlNow[C_SOFT]    = dbgSoftReq;
    lvlNow[C_CPUHARD] = cpuHardReq;
    lvlNow[C_REAR]    = btnSync[1];
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) lvlPrev <= '0;
    else       lvlPrev <= lvlNow;
  end

  assign edges = lvlNow & ~lvlPrev;

  // command decode: exactly one valid bit, nothing else
  logic cmdWr;
  logic cmdValid;
  logic [CAUSE_W-1:0] cmdReq;

  assign cmdWr    = busWrEn && (busAddr == ADR_CMD);
  assign cmdValid = cmdWr && (busWrData[DATA_W-1:CMD_BITS] == '0)
                    && $onehot(busWrData[CMD_BITS-1:0]);

  always_comb begin
    cmdReq           = '0;
    cmdReq[C_SWHARD] = cmdValid && busWrData[0];
    cmdReq[C_SOFT]   = cmdValid && busWrData[1];
  end

  assign reqVec = edges | cmdReq;

  // status, command and flag registers
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      statusQ   <= '0;
      cmdQ      <= '0;
      pwrUpFlag <= 1'b1;
    end else begin
      if (stb.start) begin
        statusQ   <= stb.cause;
        pwrUpFlag <= 1'b0;
        if (cmdValid) cmdQ <= busWrData[CMD_BITS-1:0];
      end else if (stb.finish) begin
        cmdQ <= '0;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      busRdData <= '0;
    end else if (busRdEn) begin
      case (busAddr)
        ADR_STATUS: busRdData <= statusQ;
        ADR_FLAG:   busRdData <= {{(DATA_W-1){1'b0}}, pwrUpFlag};
        default:    busRdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rccControl.sv
module rccControl
  import rcc_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               porN,
  input  logic [CAUSE_W-1:0] reqVec,
  output rccStb_t            stb,
  output logic               boardRst
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    stb.start  = !active && (|reqVec);
    stb.finish = active && (cnt == '0);
    stb.cause  = stb.start ? pickTop(reqVec) : '0;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      active <= 1'b1;
      cnt    <= LOAD;
    end else if (stb.start) begin
      active <= 1'b1;
      cnt    <= LOAD;
    end else if (stb.finish) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign boardRst = active;
endmodule

// File: rtl/rstCauseCtl.sv
module rstCauseCtl
  import rcc_pkg::*;
#(
  parameter int RST_CYCLES  = 16,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rearBtn,
  input  logic              frontBtn,
  input  logic              cpuHardReq,
  input  logic              dbgSoftReq,
  input  logic              dbgHardReq,
  input  logic              payloadReq,
  input  logic              mgrBoardReq,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              boardRst,
  output logic              pwrUpFlag
);
  rccStb_t             stb;
  logic [CAUSE_W-1:0]  reqVec;
  logic [CAUSE_W-1:0]  statusQ;
  logic [CMD_BITS-1:0] cmdQ;

  rccDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .porN(porN),
    .rearBtn(rearBtn), .frontBtn(frontBtn),
    .cpuHardReq(cpuHardReq), .dbgSoftReq(dbgSoftReq),
    .dbgHardReq(dbgHardReq), .payloadReq(payloadReq),
    .mgrBoardReq(mgrBoardReq),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .stb(stb), .reqVec(reqVec), .statusQ(statusQ),
    .cmdQ(cmdQ), .pwrUpFlag(pwrUpFlag)
  );

  rccControl #(
    .RST_CYCLES(RST_CYCLES)
  ) u_ctl (
    .clk(clk), .porN(porN), .reqVec(reqVec),
    .stb(stb), .boardRst(boardRst)
  );
endmodule

// File: rtl/rstCauseCtl_chk.sv
module rstCauseCtl_chk
  import rcc_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8
) (
  input logic                clk,
  input logic                porN,
  input logic                boardRst,
  input logic                pwrUpFlag,
  input logic                busRdEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busRdData,
  input logic [CAUSE_W-1:0]  statusQ,
  input logic [CMD_BITS-1:0] cmdQ
);
  localparam int HI_W = $clog2(RST_CYCLES + 2);
  logic [HI_W-1:0] hiCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)         hiCnt <= '0;
    else if (boardRst) hiCnt <= hiCnt + 1'b1;
    else               hiCnt <= '0;
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(boardRst) |-> hiCnt == HI_W'(RST_CYCLES));

  // R3
  status_onehot_chk: assert property (@(posedge clk) disable iff (!porN)
    $onehot0(statusQ));

  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    !$rose(boardRst) |-> $stable(statusQ));

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(pwrUpFlag) |-> $rose(boardRst));

  // R6
  cmd_selfclear_chk: assert property (@(posedge clk) disable iff (!porN)
    !boardRst |-> cmdQ == '0);

  // R8
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!porN)
    (busRdEn && busAddr == ADDR_W'(A_CMD)) |=> busRdData == '0);
endmodule

bind rstCauseCtl rstCauseCtl_chk #(
  .RST_CYCLES(RST_CYCLES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .porN(porN), .boardRst(boardRst), .pwrUpFlag(pwrUpFlag),
  .busRdEn(busRdEn), .busAddr(busAddr), .busRdData(busRdData),
  .statusQ(statusQ), .cmdQ(cmdQ)
);

// File: tb/rstCauseCtl_tb.sv
module rstCauseCtl_tb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic rearBtn = 1'b0, frontBtn = 1'b0, cpuHardReq = 1'b0, dbgSoftReq = 1'b0;
  logic dbgHardReq = 1'b0, payloadReq = 1'b0, mgrBoardReq = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic boardRst, pwrUpFlag;

  always #10 clk = ~clk;

  rstCauseCtl u_dut (
    .clk(clk), .porN(porN), .rearBtn(rearBtn), .frontBtn(frontBtn),
    .cpuHardReq(cpuHardReq), .dbgSoftReq(dbgSoftReq), .dbgHardReq(dbgHardReq),
    .payloadReq(payloadReq), .mgrBoardReq(mgrBoardReq),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .boardRst(boardRst), .pwrUpFlag(pwrUpFlag)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rdItem_t;
  rdItem_t rdQ[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data one cycle after the strobe
  logic rdSeen = 1'b0;
  always @(posedge clk) rdSeen <= busRdEn;
  always @(negedge clk) begin
    if (rdSeen && porN) begin
      if (rdQ.size() == 0) begin
        chk("R12 unexpected read", 1, 0);
      end else begin
        rdItem_t it;
        it = rdQ.pop_front();
        chk(it.tag, int'(busRdData), int'(it.exp));
      end
    end
  end

  task automatic doRead(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    busRdEn = 1'b1;
    busAddr = a;
    rdQ.push_back('{exp: e, tag: tag});
    @(negedge clk);
    busRdEn = 1'b0;
    @(negedge clk);
  endtask

  // write; returns at the negedge after the accepting posedge
  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1;
    busAddr = a;
    busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    busWrData = '0;
  endtask

  // count falling edges with boardRst high, from the current one
  task automatic measure(output int n);
    n = 0;
    while (boardRst && n < 4 * N) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idleCheck(input string tag, input int cyc);
    int hits = 0;
    for (int i = 0; i < cyc; i++) begin
      if (boardRst) hits++;
      @(negedge clk);
    end
    chk(tag, hits, 0);
  endtask

  task automatic doPor();
    @(negedge clk);
    porN = 1'b0;
    #1;
    chk("R1 boardRst during por", int'(boardRst), 1);
    chk("R1 pwrUpFlag during por", int'(pwrUpFlag), 1);
    repeat (3) @(negedge clk);
    porN = 1'b1;
    begin
      int n;
      @(negedge clk);
      measure(n);
      chk("R1 por pulse tail", n, N - 1);
    end
  endtask

  initial begin
    int n;
    repeat (2) @(negedge clk);
    // R1 power-on
    doPor();
    doRead(2'd0, 8'h00, "R1 R4 status after por");
    doRead(2'd2, 8'h01, "R5 flag after por");
    doRead(2'd1, 8'h00, "R8 command read");

    // R9 R4 R5 front button, held long
    @(negedge clk);
    frontBtn = 1'b1;
    @(negedge clk); chk("R9 no reset after 1 edge", int'(boardRst), 0);
    @(negedge clk); chk("R9 no reset after 2 edges", int'(boardRst), 0);
    @(negedge clk); chk("R9 reset on 3rd edge", int'(boardRst), 1);
    chk("R5 flag cleared", int'(pwrUpFlag), 0);
    measure(n);
    chk("R2 front pulse width", n, N);
    idleCheck("R9 held button single reset", 30);
    frontBtn = 1'b0;
    doRead(2'd0, 8'h01, "R4 front status");
    doRead(2'd2, 8'h00, "R5 flag read");

    // R2 payload pulse
    @(negedge clk); payloadReq = 1'b1;
    @(negedge clk); payloadReq = 1'b0;
    chk("R2 payload start", int'(boardRst), 1);
    measure(n);
    chk("R2 payload width", n, N);
    doRead(2'd0, 8'h04, "R3 payload status");

    // R6 soft command
    doWrite(2'd1, 8'h02);
    chk("R6 soft start", int'(boardRst), 1);
    doRead(2'd1, 8'h00, "R8 command read while active");
    measure(n);
    chk("R6 soft width", n, N - 3);
    doRead(2'd0, 8'h10, "R6 soft status");

    // R6 hard command
    doWrite(2'd1, 8'h01);
    chk("R6 hard start", int'(boardRst), 1);
    measure(n);
    chk("R2 hard width", n, N);
    doRead(2'd0, 8'h40, "R6 hard status");

    // R7 invalid commands
    doWrite(2'd1, 8'h03);
    idleCheck("R7 two bits ignored", 4);
    doWrite(2'd1, 8'h00);
    idleCheck("R7 zero ignored", 4);
    doWrite(2'd1, 8'h04);
    idleCheck("R7 high bit ignored", 4);
    doWrite(2'd1, 8'h81);
    idleCheck("R7 mixed bits ignored", 4);
    doRead(2'd0, 8'h40, "R7 status unchanged");

    // R10 simultaneous
    @(negedge clk); payloadReq = 1'b1; cpuHardReq = 1'b1;
    @(negedge clk); payloadReq = 1'b0; cpuHardReq = 1'b0;
    measure(n);
    doRead(2'd0, 8'h20, "R10 cpu over payload");
    @(negedge clk); dbgHardReq = 1'b1; mgrBoardReq = 1'b1;
    @(negedge clk); dbgHardReq = 1'b0; mgrBoardReq = 1'b0;
    measure(n);
    doRead(2'd0, 8'h08, "R10 dbg hard over board");

    // R11 request during active reset dropped
    @(negedge clk); payloadReq = 1'b1;
    @(negedge clk); payloadReq = 1'b0;
    repeat (3) @(negedge clk);
    cpuHardReq = 1'b1;
    @(negedge clk); cpuHardReq = 1'b0;
    measure(n);
    chk("R11 width unaffected", n, N - 4);
    idleCheck("R11 no later reset", 6);
    doRead(2'd0, 8'h04, "R11 status kept");

    // R11 held level request: one reset only
    @(negedge clk); dbgSoftReq = 1'b1;
    @(negedge clk);
    measure(n);
    idleCheck("R11 held level single reset", 8);
    dbgSoftReq = 1'b0;
    doRead(2'd0, 8'h10, "R3 dbg soft status");

    // R9 rear button
    @(negedge clk); rearBtn = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R9 rear start", int'(boardRst), 1);
    rearBtn = 1'b0;
    measure(n);
    doRead(2'd0, 8'h80, "R3 rear status");

    // R5 second power-on sets flag again
    doPor();
    doRead(2'd0, 8'h00, "R1 status cleared by por");
    doRead(2'd2, 8'h01, "R5 flag set by por");

    repeat (3) @(negedge clk);
    chk("R12 read queue drained", rdQ.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule